// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter

This block sends bytes on an asynchronous serial line. It is driven through a small byte-wide register bank. The host has a 2-bit offset, read and write strobes, an 8-bit write bus and a registered read bus.

A holding register takes each byte from the host. When the line is free, a separate shift register takes that byte and puts it on the wire. This leaves the holding register free for the next byte while the current one is still going out. A programmable 16-bit divisor makes a tick at sixteen times the bit rate. One bit of the line-control byte swaps offsets 0 and 1 between the data registers and the two divisor bytes.

A single interrupt cause, "holding register empty", is tracked. A host can either take the interrupt output or poll the identification code at offset 2. When it sees the empty code, it writes the next byte. Repeating this gives a stream of frames with no idle gap between them.

Top module: `uart_tx_regs`

## Requirements
- R1: After reset the serial output is high, the interrupt output is low, and the line-control, enable and divisor registers read 0. The identification register reads 8'h01.
- R2: Offset 3 is the line-control byte, and its bit 7 is the bank bit. With bank=1, offsets 0 and 1 write and read the divisor low and high bytes. With bank=0, offset 0 writes the holding register and reads 0, and offset 1 writes and reads the enable byte, of which only bit 1 is kept. Offset 2 reads the identification code. Read data appears on the cycle after the read strobe.
- R3: A frame is one low start bit, then the data bits LSB first, then high stop bits. The output is high whenever no frame is in progress.
- R4: Line-control bits 1:0 set the data length (00=5, 01=6, 10=7, 11=8). Bit 2 selects one stop bit when 0 and two stop bits when 1. Both are captured when a frame starts.
- R5: Every bit lasts 16 divisor periods, which is 16*D clock cycles for divisor D. A divisor of 0 acts as 1.
- R6: When the shift register takes a byte, the holding register is freed. A byte that is waiting when the last stop bit ends starts its start bit with no idle cycle.
- R7: With enable bit 1 set and the empty cause pending, the identification register reads 8'h02. Otherwise it reads 8'h01.
- R8: The interrupt output is high exactly when the empty cause is pending and enable bit 1 is set. A write to the holding register clears the cause. A read of the identification register that returns 8'h02 also clears it.
- R9: The empty cause becomes pending when the shift register takes a byte from the holding register. It also becomes pending when enable bit 1 is written as 1 while the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register offset |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd` |
| irq | output | 1 | Interrupt, active high |
| txd | output | 1 | Serial output |

## Verification
A wrong bit or shift counter shows up at `txd`. It appears either as a wrong data or stop level at the middle of a bit, or as a start edge of the next frame that is off by whole bit times. The sweep measures the start-to-start distance of back-to-back frames for every length, stop and divisor setting. Because of this, a miscounted bit or an inserted gap is caught within one frame. A stuck or wrongly set pending flag shows up on the very next identification read, and as `irq` disagreeing with the enable bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_IEN  = 2'd1;
  localparam logic [1:0] OFS_IID  = 2'd2;
  localparam logic [1:0] OFS_LCTL = 2'd3;

  localparam logic [7:0] IID_NONE  = 8'h01;
  localparam logic [7:0] IID_EMPTY = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_cnt;

  // zero divisor behaves as one: tick every cycle
  assign last_cnt = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick     = (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              thr_full,
  input  logic [WORD_W-1:0] thr_data,
  input  logic [1:0]        wlen,
  input  logic              two_stop,
  output logic              load,
  output logic              busy,
  output logic              txd
);
  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(WORD_W);

  tx_state_e         state_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_q;
  logic [WORD_W-1:0] sh_q;
  logic              stop_left_q;
  logic              txd_q;
  logic              bit_end;
  logic              frame_end;

  assign bit_end   = tick && (sub_q == SUB_W'(OVS - 1));
  assign frame_end = bit_end && (state_q == ST_STOP) && !stop_left_q;
  assign load      = tick && thr_full && ((state_q == ST_IDLE) || frame_end);
  assign busy      = (state_q != ST_IDLE);
  assign txd       = txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sub_q       <= '0;
      idx_q       <= '0;
      last_q      <= '0;
      sh_q        <= '0;
      stop_left_q <= 1'b0;
      txd_q       <= 1'b1;
    end else if (load) begin
      state_q     <= ST_START;
      sub_q       <= '0;
      sh_q        <= thr_data;
      last_q      <= IDX_W'(4) + IDX_W'(wlen);
      stop_left_q <= two_stop;
      txd_q       <= 1'b0;
    end else if (tick && busy) begin
      sub_q <= bit_end ? '0 : sub_q + SUB_W'(1);
      if (bit_end) begin
        unique case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            txd_q   <= sh_q[0];
          end
          ST_DATA: begin
            if (idx_q == last_q) begin
              state_q <= ST_STOP;
              txd_q   <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              sh_q  <= sh_q >> 1;
              txd_q <= sh_q[1];
            end
          end
          ST_STOP: begin
            if (stop_left_q) stop_left_q <= 1'b0;
            else state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_thre_irq.sv
module uart_thre_irq
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       thr_wr,
  input  logic       load,
  input  logic       en_set,
  input  logic       iid_rd,
  input  logic       en,
  output logic       pend,
  output logic       irq,
  output logic [7:0] iid
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b1;
    else if (thr_wr) pend_q <= 1'b0;
    else if (load || en_set) pend_q <= 1'b1;
    else if (iid_rd && en && pend_q) pend_q <= 1'b0;
  end

  assign pend = pend_q;
  assign irq  = pend_q && en;
  assign iid  = (pend_q && en) ? IID_EMPTY : IID_NONE;
endmodule

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
  import uart_tx_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             irq,
  output logic             txd
);
  localparam int DIV_W = 2 * BUS_W;

  logic [BUS_W-1:0] lctl_q;
  logic             ien_q;
  logic [DIV_W-1:0] div_q;
  logic [BUS_W-1:0] thr_q;
  logic             thr_full_q;
  logic [BUS_W-1:0] rdata_q;

  logic             bank;
  logic             thr_wr;
  logic             en_wr;
  logic             en_set;
  logic             iid_rd;
  logic             tick;
  logic             load;
  logic             busy;
  logic             pend;
  logic [7:0]       iid;

  assign bank   = lctl_q[7];
  assign thr_wr = wr && (addr == OFS_DATA) && !bank;
  assign en_wr  = wr && (addr == OFS_IEN) && !bank;
  assign en_set = en_wr && wdata[1] && !thr_full_q;
  assign iid_rd = rd && (addr == OFS_IID);

  always_ff @(posedge clk) begin
    if (rst) begin
      lctl_q     <= '0;
      ien_q      <= 1'b0;
      div_q      <= '0;
      thr_q      <= '0;
      thr_full_q <= 1'b0;
    end else begin
      if (wr && addr == OFS_LCTL) lctl_q <= wdata;
      if (en_wr) ien_q <= wdata[1];
      if (wr && bank && addr == OFS_DATA) div_q[BUS_W-1:0] <= wdata;
      if (wr && bank && addr == OFS_IEN)  div_q[DIV_W-1:BUS_W] <= wdata;
      if (thr_wr) begin
        thr_q      <= wdata;
        thr_full_q <= 1'b1;
      end else if (load) begin
        thr_full_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd) begin
      unique case (addr)
        OFS_DATA: rdata_q <= bank ? div_q[BUS_W-1:0] : '0;
        OFS_IEN:  rdata_q <= bank ? div_q[DIV_W-1:BUS_W]
                                  : BUS_W'({ien_q, 1'b0});
        OFS_IID:  rdata_q <= BUS_W'(iid);
        default:  rdata_q <= lctl_q;
      endcase
    end
  end

  assign rdata = rdata_q;

  uart_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk     (clk),
    .rst     (rst),
    .divisor (div_q),
    .tick    (tick)
  );

  uart_tx_shifter #(.WORD_W(BUS_W), .OVS(OVS)) i_shift (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .thr_full (thr_full_q),
    .thr_data (thr_q),
    .wlen     (lctl_q[1:0]),
    .two_stop (lctl_q[2]),
    .load     (load),
    .busy     (busy),
    .txd      (txd)
  );

  uart_thre_irq i_irq (
    .clk    (clk),
    .rst    (rst),
    .thr_wr (thr_wr),
    .load   (load),
    .en_set (en_set),
    .iid_rd (iid_rd),
    .en     (ien_q),
    .pend   (pend),
    .irq    (irq),
    .iid    (iid)
  );
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] addr,
  input logic       wr,
  input logic       rd,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       txd,
  input logic       bank,
  input logic       ien,
  input logic       load,
  input logic       busy,
  input logic       pend
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ien); // R8

  AST_THR_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd0 && !bank) |=> !irq); // R8

  AST_HANDOFF_SETS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (load && !(wr && addr == 2'd0 && !bank)) |=> pend); // R9

  AST_IID_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == 2'd2) |=> (rdata == 8'h01 || rdata == 8'h02)); // R7

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R3

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> !txd); // R6
endmodule

bind uart_tx_regs uart_tx_checker i_chk (
  .clk   (clk),
  .rst   (rst),
  .addr  (addr),
  .wr    (wr),
  .rd    (rd),
  .rdata (rdata),
  .irq   (irq),
  .txd   (txd),
  .bank  (bank),
  .ien   (ien_q),
  .load  (load),
  .busy  (busy),
  .pend  (pend)
);

// File: tb/test_uart_tx_regs.sv
`timescale 1ns/1ps
module test_uart_tx_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       txd;

  int     n_chk = 0;
  int     n_err = 0;
  longint cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_regs i_uart_tx_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .irq(irq), .txd(txd)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // waits for a start edge, checks the frame, returns detection cycle
  task automatic rx_frame(input int dv, input int nb, input int ns,
                          input logic [7:0] exp, output longint t);
    logic [7:0] got;
    got = '0;
    do @(negedge clk); while (txd !== 1'b0);
    t = cyc;
    repeat (8 * dv) @(negedge clk);
    check(txd === 1'b0, "R3 start bit", txd, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (16 * dv) @(negedge clk);
      got[i] = txd;
    end
    check(got == (exp & 8'((1 << nb) - 1)), "R3 R4 data bits", got,
          exp & 8'((1 << nb) - 1));
    for (int s = 0; s < ns; s++) begin
      repeat (16 * dv) @(negedge clk);
      check(txd === 1'b1, "R4 stop bit", txd, 1);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    longint t0, t1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 txd idle", txd, 1);
    check(irq === 1'b0, "R1 irq", irq, 0);
    reg_rd(2'd3, d); check(d == 8'h00, "R1 line control", d, 0);
    reg_rd(2'd1, d); check(d == 8'h00, "R1 enable", d, 0);
    reg_rd(2'd2, d); check(d == 8'h01, "R1 iid", d, 1);
    reg_wr(2'd3, 8'h80);
    reg_rd(2'd0, d); check(d == 8'h00, "R1 divisor low", d, 0);
    reg_rd(2'd1, d); check(d == 8'h00, "R1 divisor high", d, 0);

    // R2 bank switching and readback
    reg_wr(2'd0, 8'h34);
    reg_wr(2'd1, 8'h12);
    reg_rd(2'd0, d); check(d == 8'h34, "R2 divisor low", d, 8'h34);
    reg_rd(2'd1, d); check(d == 8'h12, "R2 divisor high", d, 8'h12);
    reg_wr(2'd3, 8'h07);
    reg_rd(2'd3, d); check(d == 8'h07, "R2 line control", d, 8'h07);
    reg_rd(2'd1, d); check(d == 8'h00, "R2 enable untouched", d, 0);
    reg_rd(2'd0, d); check(d == 8'h00, "R2 data read zero", d, 0);
    reg_wr(2'd1, 8'hFF);
    reg_rd(2'd1, d); check(d == 8'h02, "R2 enable bit1 only", d, 8'h02);
    check(txd === 1'b1, "R2 enable write sends nothing", txd, 1);
    // R9 enable with empty holding register raises cause
    check(irq === 1'b1, "R9 enable raises", irq, 1);
    reg_wr(2'd1, 8'h00);
    check(irq === 1'b0, "R8 irq masked", irq, 0);
    reg_rd(2'd2, d); check(d == 8'h01, "R7 masked iid", d, 1);

    // sweep divisor, length and stop bits with back-to-back frames
    for (int dsel = 0; dsel < 4; dsel++) begin
      for (int wl = 0; wl < 4; wl++) begin
        for (int sb = 0; sb < 2; sb++) begin
          int dv, nb, ns;
          logic [7:0] a, b;
          dv = (dsel == 0) ? 1 : dsel;
          nb = 5 + wl;
          ns = 1 + sb;
          a  = 8'hA5 ^ 8'(dsel * 29 + wl * 7 + sb);
          b  = ~a ^ 8'(wl << 3);
          reg_wr(2'd3, 8'h80);
          reg_wr(2'd0, 8'(dsel));
          reg_wr(2'd1, 8'h00);
          reg_wr(2'd3, 8'(sb * 4 + wl));
          reg_wr(2'd1, 8'h02);
          fork
            begin
              rx_frame(dv, nb, ns, a, t0);
              rx_frame(dv, nb, ns, b, t1);
            end
            begin
              logic [7:0] r;
              reg_wr(2'd0, a);
              check(irq === 1'b0, "R8 write clears", irq, 0);
              r = 8'h01;
              for (int k = 0; k < 200 && r != 8'h02; k++) reg_rd(2'd2, r);
              check(r == 8'h02, "R6 R9 holding freed", r, 2);
              reg_wr(2'd0, b);
            end
          join
          // R5 R6: start-to-start distance is exactly one frame
          check((t1 - t0) == longint'((1 + nb + ns) * 16 * dv), "R5 R6 frame length",
                t1 - t0, (1 + nb + ns) * 16 * dv);
          check(irq === 1'b1, "R8 irq pending", irq, 1);
          reg_rd(2'd2, d); check(d == 8'h02, "R7 iid empty", d, 2);
          check(irq === 1'b0, "R8 read clears irq", irq, 0);
          reg_rd(2'd2, d); check(d == 8'h01, "R8 read clears code", d, 1);
          repeat (16 * dv) @(negedge clk);
          check(txd === 1'b1, "R3 idle after frames", txd, 1);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule